// File: doc/BRIEF.md
# Hamming SEC-DED Codec for Byte Data

This block protects an 8-bit data word with a single-error-correcting, double-error-detecting Hamming code. It has two independent channels that share a clock and a reset. The encode channel turns a data byte into a 13-bit codeword. The decode channel takes a 13-bit codeword that may have been corrupted in storage or transit. It returns the repaired data, the codeword position that was repaired, and a status code.

Each channel registers its result and presents it one clock after a valid input. The valid flag of each channel is held in a two-state machine with the states `CH_EMPTY` and `CH_FULL`. It moves along these transitions:

- **fill**: `CH_EMPTY` to `CH_FULL` when a valid input arrives.
- **refill**: `CH_FULL` to `CH_FULL` on a further valid input.
- **drain**: `CH_FULL` to `CH_EMPTY` when no valid input arrives.
- **idle**: `CH_EMPTY` to `CH_EMPTY` when there is no input.

While a channel sees no valid input, its payload register holds its last value.

In the codeword, check bits sit at the power-of-two positions. Because of this layout, the recomputed check results read as a binary number (the syndrome) that directly names a single failing position. One extra parity bit over the whole word separates single errors from double errors.

Top module: `hsd_codec`

## Requirements
- R1: Codeword bit index p holds position p. Position 0 is the overall parity bit. Positions 1, 2, 4 and 8 are check bits. Data bit i (bit 0 = LSB) sits at positions 3, 5, 6, 7, 9, 10, 11 and 12 for i = 0 to 7, in that order.
- R2: The check bit at position 2^k is the even parity of every position from 1 to 12 whose index has bit k set. Position 0 makes the parity of all 13 bits even.
- R3: `enc_valid_o` and `dec_valid_o` are high in exactly the cycle after the cycle in which the matching `*_valid_i` was sampled high, and their results appear in that same cycle.
- R4: A codeword with no error decodes with status 0 (clean), position 0, `dec_ok_o` high, and the original data.
- R5: A single flipped bit at position 1 to 12 (overall parity fails, syndrome 1 to 12) decodes with status 1 (corrected), position equal to the syndrome, `dec_ok_o` high, and the original data.
- R6: A flip of position 0 alone (overall parity fails, syndrome 0) decodes with status 1, position 0, `dec_ok_o` high, and the data unchanged.
- R7: An even overall parity with a nonzero syndrome decodes with status 2 (uncorrectable), position 0, and `dec_ok_o` low. The data output carries the data-position bits of the received word, not repaired.
- R8: A failing overall parity with a syndrome of 13 to 15 decodes as status 2, position 0, and `dec_ok_o` low, with the data not repaired.
- R9: A channel whose valid input is low keeps its data, code, position and status outputs unchanged.
- R10: During reset, both valid outputs, `dec_ok_o`, the code, the data, the position and the status are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encode request |
| enc_data_i | input | 8 | Data byte to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_code_o | output | 13 | Encoded codeword |
| dec_valid_i | input | 1 | Decode request |
| dec_code_i | input | 13 | Received codeword |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 8 | Repaired data |
| dec_pos_o | output | 4 | Repaired position (0 if none or uncorrectable) |
| dec_status_o | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| dec_ok_o | output | 1 | Valid result with usable data |

## Verification
The bench encodes every byte and decodes it both clean and with each of the 13 single-bit flips. A design with a misplaced data or check position would give a wrong codeword or repair the wrong bit. A flip of the parity bit alone is checked separately, since a design that trusted the zero syndrome blindly would report the word as clean. Sampled double flips must come back as uncorrectable; a design that looked only at the syndrome would "repair" a third bit and corrupt the data silently. Triple flips that yield syndromes 13 and 15 probe the out-of-range syndrome path, which a careless design would turn into a flip of a nonexistent bit while claiming success.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    typedef enum logic [1:0] {
        DEC_CLEAN = 2'd0,
        DEC_FIXED = 2'd1,
        DEC_FATAL = 2'd2
    } dec_stat_e;

    typedef enum logic {
        CH_EMPTY = 1'b0,
        CH_FULL  = 1'b1
    } ch_state_e;

    function automatic bit is_pow2(int unsigned p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

    // Smallest number of check bits r with 2^r >= data + r + 1.
    function automatic int unsigned chk_bits(int unsigned dw);
        int unsigned res;
        bit          found;
        res   = 16;
        found = 1'b0;
        for (int unsigned r = 1; r < 16; r++) begin
            if (!found && ((32'd1 << r) >= dw + r + 1)) begin
                res   = r;
                found = 1'b1;
            end
        end
        return res;
    endfunction

    // Codeword position of data bit idx: the idx-th non power of two above 0.
    function automatic int unsigned data_pos(int unsigned idx);
        int unsigned cnt;
        int unsigned res;
        bit          found;
        cnt   = 0;
        res   = 0;
        found = 1'b0;
        for (int unsigned p = 1; p < 64; p++) begin
            if (!is_pow2(p)) begin
                if (!found && cnt == idx) begin
                    res   = p;
                    found = 1'b1;
                end
                cnt++;
            end
        end
        return res;
    endfunction

    // Data bit index held at codeword position p (p not a power of two).
    function automatic int unsigned data_idx(int unsigned p);
        int unsigned cnt;
        cnt = 0;
        for (int unsigned q = 1; q < 64; q++) begin
            if (q < p && !is_pow2(q)) cnt++;
        end
        return cnt;
    endfunction

    // Positions covered by check k: every index with bit k set.
    function automatic logic [63:0] cover_mask(int unsigned k);
        logic [63:0] m;
        m = '0;
        for (int unsigned p = 1; p < 64; p++) begin
            if (((p >> k) & 1) == 1) m = m | (64'd1 << p);
        end
        return m;
    endfunction

endpackage

// File: rtl/hsd_encoder.sv
module hsd_encoder
    import hsd_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CHK_W  = chk_bits(DATA_W),
    parameter int unsigned CW_W   = DATA_W + CHK_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   code_o
);

    logic [CW_W-1:1] placed;
    logic [CW_W-1:1] body;
    logic [CHK_W-1:0] chk;

    // Scatter data onto non power-of-two positions; check slots stay zero.
    for (genvar p = 1; p < CW_W; p++) begin : g_place
        if (is_pow2(p)) begin : g_slot
            assign placed[p] = 1'b0;
        end else begin : g_data
            localparam int unsigned DI = data_idx(p);
            assign placed[p] = data_i[DI];
        end
    end

    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [63:0] CM = cover_mask(k);
        assign chk[k] = ^(placed & CM[CW_W-1:1]);
    end

    for (genvar p = 1; p < CW_W; p++) begin : g_body
        if (is_pow2(p)) begin : g_c
            assign body[p] = chk[$clog2(p)];
        end else begin : g_d
            assign body[p] = placed[p];
        end
    end

    assign code_o = {body, ^body};

endmodule

// File: rtl/hsd_syndrome.sv
module hsd_syndrome
    import hsd_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CHK_W  = chk_bits(DATA_W),
    parameter int unsigned CW_W   = DATA_W + CHK_W + 1
) (
    input  logic [CW_W-1:0]  code_i,
    output logic [CHK_W-1:0] syn_o,
    output logic             par_err_o
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_syn
        localparam logic [63:0] CM = cover_mask(k);
        assign syn_o[k] = ^(code_i & CM[CW_W-1:0]);
    end

    assign par_err_o = ^code_i;

endmodule

// File: rtl/hsd_corrector.sv
module hsd_corrector
    import hsd_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CHK_W  = chk_bits(DATA_W),
    parameter int unsigned CW_W   = DATA_W + CHK_W + 1
) (
    input  logic [CW_W-1:0]   code_i,
    input  logic [CHK_W-1:0]  syn_i,
    input  logic              par_err_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  pos_o,
    output logic [1:0]        status_o
);

    logic            syn_zero;
    logic            syn_in_range;
    logic            fix_en;
    logic [CW_W-1:0] flip;
    logic [CW_W-1:0] fixed;
    dec_stat_e       stat;

    assign syn_zero     = (syn_i == '0);
    assign syn_in_range = (syn_i <= CHK_W'(CW_W - 1));
    assign fix_en       = par_err_i && !syn_zero && syn_in_range;

    for (genvar p = 0; p < CW_W; p++) begin : g_flip
        assign flip[p] = fix_en && (syn_i == CHK_W'(p));
    end

    assign fixed = code_i ^ flip;

    for (genvar i = 0; i < DATA_W; i++) begin : g_get
        localparam int unsigned DP = data_pos(i);
        assign data_o[i] = fixed[DP];
    end

    always_comb begin
        unique case ({par_err_i, syn_zero})
            2'b01:   stat = DEC_CLEAN;
            2'b11:   stat = DEC_FIXED;
            2'b10:   stat = syn_in_range ? DEC_FIXED : DEC_FATAL;
            default: stat = DEC_FATAL;
        endcase
    end

    assign status_o = stat;
    assign pos_o    = fix_en ? syn_i : '0;

endmodule

// File: rtl/hsd_chan_reg.sv
module hsd_chan_reg
    import hsd_pkg::*;
#(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic         valid_o,
    output logic [W-1:0] data_o
);

    ch_state_e    state_q;
    ch_state_e    state_d;
    logic [W-1:0] pay_q;

    always_comb begin
        unique case (state_q)
            CH_EMPTY: state_d = load_i ? CH_FULL : CH_EMPTY;
            CH_FULL:  state_d = load_i ? CH_FULL : CH_EMPTY;
            default:  state_d = CH_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_EMPTY;
            pay_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_i) pay_q <= data_i;
        end
    end

    always_comb begin
        valid_o = (state_q == CH_FULL);
        data_o  = pay_q;
    end

endmodule

// File: rtl/hsd_codec.sv
module hsd_codec
    import hsd_pkg::*;
#(
    parameter  int unsigned DATA_W = 8,
    localparam int unsigned CHK_W  = chk_bits(DATA_W),
    localparam int unsigned CW_W   = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CW_W-1:0]   enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CW_W-1:0]   dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CHK_W-1:0]  dec_pos_o,
    output logic [1:0]        dec_status_o,
    output logic              dec_ok_o
);

    localparam int unsigned DPAY_W = DATA_W + CHK_W + 2;

    logic [CW_W-1:0]   enc_code;
    logic [CHK_W-1:0]  syn;
    logic              par_err;
    logic [DATA_W-1:0] cor_data;
    logic [CHK_W-1:0]  cor_pos;
    logic [1:0]        cor_stat;
    logic [DPAY_W-1:0] dpay_q;

    hsd_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code)
    );

    hsd_chan_reg #(.W(CW_W)) u_enc_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (enc_valid_i),
        .data_i  (enc_code),
        .valid_o (enc_valid_o),
        .data_o  (enc_code_o)
    );

    hsd_syndrome #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_syn (
        .code_i    (dec_code_i),
        .syn_o     (syn),
        .par_err_o (par_err)
    );

    hsd_corrector #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_cor (
        .code_i    (dec_code_i),
        .syn_i     (syn),
        .par_err_i (par_err),
        .data_o    (cor_data),
        .pos_o     (cor_pos),
        .status_o  (cor_stat)
    );

    hsd_chan_reg #(.W(DPAY_W)) u_dec_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (dec_valid_i),
        .data_i  ({cor_data, cor_pos, cor_stat}),
        .valid_o (dec_valid_o),
        .data_o  (dpay_q)
    );

    assign {dec_data_o, dec_pos_o, dec_status_o} = dpay_q;
    assign dec_ok_o = dec_valid_o && (dec_status_o != 2'(DEC_FATAL));

endmodule

// File: rtl/hsd_codec_chk.sv
module hsd_codec_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CHK_W  = 4,
    parameter int unsigned CW_W   = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enc_valid_i,
    input logic              enc_valid_o,
    input logic [CW_W-1:0]   enc_code_o,
    input logic              dec_valid_i,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [CHK_W-1:0]  dec_pos_o,
    input logic [1:0]        dec_status_o,
    input logic              dec_ok_o
);

    p_enc_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);
    p_enc_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> !enc_valid_o);
    p_dec_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);
    p_dec_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> !dec_valid_o);

    p_even_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> (^enc_code_o) == 1'b0);

    p_status_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_status_o != 2'd3);

    p_pos_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_pos_o <= CHK_W'(CW_W - 1));

    p_fatal_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_status_o == 2'd2) |-> (dec_pos_o == '0 && !dec_ok_o));

    p_clean_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_status_o == 2'd0) |-> (dec_pos_o == '0 && dec_ok_o));

    p_enc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> $stable(enc_code_o));
    p_dec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_pos_o) && $stable(dec_status_o)));

    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |-> (!enc_valid_o && !dec_valid_o && !dec_ok_o));

endmodule

bind hsd_codec hsd_codec_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enc_valid_i  (enc_valid_i),
    .enc_valid_o  (enc_valid_o),
    .enc_code_o   (enc_code_o),
    .dec_valid_i  (dec_valid_i),
    .dec_valid_o  (dec_valid_o),
    .dec_data_o   (dec_data_o),
    .dec_pos_o    (dec_pos_o),
    .dec_status_o (dec_status_o),
    .dec_ok_o     (dec_ok_o)
);

// File: tb/hsd_codec_tb.sv
module hsd_codec_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CW = 13;
    localparam int PW = 4;

    typedef struct packed {
        logic [7:0]  d;
        logic [12:0] m;
        logic [1:0]  st;
        logic [3:0]  pos;
        logic [3:0]  rq;
    } vec_t;

    // data, flip mask, expected status, expected position, requirement number
    localparam vec_t VEC [9] = '{
        '{8'h00, 13'h0000, 2'd0, 4'd0,  4'd4},
        '{8'hFF, 13'h0000, 2'd0, 4'd0,  4'd4},
        '{8'hA5, 13'h0001, 2'd1, 4'd0,  4'd6},
        '{8'h3C, 13'h1000, 2'd1, 4'd12, 4'd5},
        '{8'h81, 13'h0100, 2'd1, 4'd8,  4'd5},
        '{8'h5A, 13'h0028, 2'd2, 4'd0,  4'd7},
        '{8'h00, 13'h0081, 2'd2, 4'd0,  4'd7},
        '{8'h77, 13'h1006, 2'd2, 4'd0,  4'd8},
        '{8'hC3, 13'h0112, 2'd2, 4'd0,  4'd8}
    };

    logic          clk;
    logic          rst_n;
    logic          enc_valid_i;
    logic [DW-1:0] enc_data_i;
    logic          enc_valid_o;
    logic [CW-1:0] enc_code_o;
    logic          dec_valid_i;
    logic [CW-1:0] dec_code_i;
    logic          dec_valid_o;
    logic [DW-1:0] dec_data_o;
    logic [PW-1:0] dec_pos_o;
    logic [1:0]    dec_status_o;
    logic          dec_ok_o;

    int n_checks = 0;
    int n_fail   = 0;

    hsd_codec u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_valid_i  (enc_valid_i),
        .enc_data_i   (enc_data_i),
        .enc_valid_o  (enc_valid_o),
        .enc_code_o   (enc_code_o),
        .dec_valid_i  (dec_valid_i),
        .dec_code_i   (dec_code_i),
        .dec_valid_o  (dec_valid_o),
        .dec_data_o   (dec_data_o),
        .dec_pos_o    (dec_pos_o),
        .dec_status_o (dec_status_o),
        .dec_ok_o     (dec_ok_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference encoder written from the position layout of R1 and R2.
    function automatic logic [12:0] ref_enc(input logic [7:0] d);
        logic [12:0] c;
        c = '0;
        c[3] = d[0]; c[5] = d[1]; c[6] = d[2]; c[7] = d[3];
        c[9] = d[4]; c[10] = d[5]; c[11] = d[6]; c[12] = d[7];
        c[1] = c[3] ^ c[5] ^ c[7] ^ c[9] ^ c[11];
        c[2] = c[3] ^ c[6] ^ c[7] ^ c[10] ^ c[11];
        c[4] = c[5] ^ c[6] ^ c[7] ^ c[12];
        c[8] = c[9] ^ c[10] ^ c[11] ^ c[12];
        c[0] = ^c[12:1];
        return c;
    endfunction

    function automatic logic [7:0] raw_data(input logic [12:0] c);
        return {c[12], c[11], c[10], c[9], c[7], c[6], c[5], c[3]};
    endfunction

    function automatic string req_name(input logic [3:0] rq);
        case (rq)
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] ed, input logic [12:0] dc);
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = ed;
        dec_valid_i = 1'b1;
        dec_code_i  = dc;
        @(negedge clk);
    endtask

    task automatic check_dec(input string req, input logic [7:0] d,
                             input logic [1:0] st, input logic [3:0] pos);
        check(req, "status", 32'(dec_status_o), 32'(st));
        check(req, "pos",    32'(dec_pos_o),    32'(pos));
        check(req, "data",   32'(dec_data_o),   32'(d));
        check(req, "ok",     32'(dec_ok_o),     32'(st != 2'd2));
    endtask

    task automatic check_reset_state();
        check("R10", "enc_valid", 32'(enc_valid_o),  32'h0);
        check("R10", "dec_valid", 32'(dec_valid_o),  32'h0);
        check("R10", "code",      32'(enc_code_o),   32'h0);
        check("R10", "data",      32'(dec_data_o),   32'h0);
        check("R10", "pos",       32'(dec_pos_o),    32'h0);
        check("R10", "status",    32'(dec_status_o), 32'h0);
        check("R10", "ok",        32'(dec_ok_o),     32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R3 act=timeout exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [12:0] cw;
        logic [12:0] bad;

        rst_n       = 1'b0;
        enc_valid_i = 1'b0;
        enc_data_i  = '0;
        dec_valid_i = 1'b0;
        dec_code_i  = '0;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);

        // Table of corner vectors (R4 to R8 cases named per entry).
        foreach (VEC[n]) begin
            cw  = ref_enc(VEC[n].d);
            bad = cw ^ VEC[n].m;
            run_op(VEC[n].d, bad);
            check("R1", "code", 32'(enc_code_o), 32'(cw));
            check_dec(req_name(VEC[n].rq),
                      (VEC[n].st == 2'd2) ? raw_data(bad) : VEC[n].d,
                      VEC[n].st, VEC[n].pos);
        end

        // Every byte: encode (R1, R2), clean decode (R4), every single flip (R5, R6).
        for (int d = 0; d < 256; d++) begin
            cw = ref_enc(8'(d));
            run_op(8'(d), cw);
            check("R2", "code", 32'(enc_code_o), 32'(cw));
            check_dec("R4", 8'(d), 2'd0, 4'd0);
            for (int p = 0; p < 13; p++) begin
                run_op(8'(d), cw ^ (13'd1 << p));
                if (p == 0) check_dec("R6", 8'(d), 2'd1, 4'd0);
                else        check_dec("R5", 8'(d), 2'd1, 4'(p));
            end
        end

        // Sampled double flips: always uncorrectable (R7).
        for (int d = 0; d < 256; d += 51) begin
            cw = ref_enc(8'(d));
            for (int a = 0; a < 13; a++) begin
                for (int b = a + 1; b < 13; b++) begin
                    bad = cw ^ (13'd1 << a) ^ (13'd1 << b);
                    run_op(8'(d), bad);
                    check_dec("R7", raw_data(bad), 2'd2, 4'd0);
                end
            end
        end

        // Latency and hold: idle, then one request, then inputs change with valid low.
        @(negedge clk);
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        @(negedge clk);
        check("R3", "enc_valid idle", 32'(enc_valid_o), 32'h0);
        cw = ref_enc(8'h5A);
        enc_valid_i = 1'b1;
        enc_data_i  = 8'h5A;
        dec_valid_i = 1'b1;
        dec_code_i  = cw ^ 13'h0040;
        #1;
        check("R3", "dec_valid early", 32'(dec_valid_o), 32'h0);
        @(negedge clk);
        check("R3", "enc_valid", 32'(enc_valid_o), 32'h1);
        check("R3", "dec_valid", 32'(dec_valid_o), 32'h1);
        check_dec("R5", 8'h5A, 2'd1, 4'd6);
        enc_valid_i = 1'b0;
        enc_data_i  = 8'hFF;
        dec_valid_i = 1'b0;
        dec_code_i  = 13'h0003;
        @(negedge clk);
        check("R3", "enc_valid drop", 32'(enc_valid_o), 32'h0);
        check("R3", "dec_valid drop", 32'(dec_valid_o), 32'h0);
        check("R9", "code held", 32'(enc_code_o), 32'(cw));
        check("R9", "data held", 32'(dec_data_o), 32'h5A);
        check("R9", "pos held", 32'(dec_pos_o), 32'h6);
        check("R9", "status held", 32'(dec_status_o), 32'h1);
        repeat (2) @(negedge clk);
        check("R9", "code still held", 32'(enc_code_o), 32'(cw));
        check("R9", "data still held", 32'(dec_data_o), 32'h5A);

        // Reset in the middle of traffic.
        run_op(8'h99, ref_enc(8'h99) ^ 13'h0006);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        @(negedge clk);
        check("R10", "valid after release", 32'(dec_valid_o), 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule